// File: doc/BRIEF.md
# Interrupt Aggregator with MSI/INTx Select

This block gathers a bank of mailbox interrupt sources and one application interrupt line into a single interrupt level. It then reports that level to a PCI Express link controller as requests for messages. Each mailbox has a status bit and an enable bit. A source sets its status bit with a one-cycle pulse. Software clears it with a write-one-to-clear strobe. One enable word holds the mailbox enables plus one enable for the application line. The level is the OR of every enabled, active source.

Two configuration-space bits choose how the level leaves the block:
- The legacy-disable bit is a copy of Command register bit 10.
- The MSI-enable bit is a copy of MSI control bit 0.

While MSI is enabled, each new high period of the level yields one MSI request. While only the legacy path is allowed, the block follows the level with virtual INTA assert and deassert requests. If software briefly enables both types while it switches modes, MSI takes new requests and any INTA that is still asserted is deasserted. A high level that was carried by INTA is re-sent as an MSI, so no interrupt is lost.

The three request outputs form one valid/ready channel toward the message sender, with `msg_ack` as ready. At most one request is visible at a time. A visible request stays unchanged until a cycle with `msg_ack` high completes it. After every handshake there is one idle cycle. `msg_ack` is ignored while no request is visible.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status bits, enable bits and message state are clear, and no request output is high.
- R2: The internal level is the OR of (status[i] AND enable[i]) for mailboxes 0..7 and (app_irq AND enable bit 8). A set status bit with its enable clear produces no request.
- R3: A status bit is set one cycle after a set pulse. It is cleared one cycle after a clear strobe whose mask has that bit set. When a set pulse and a clear of the same bit fall in one cycle, the set wins.
- R4: With legacy allowed (legacy-disable 0 and MSI-enable 0), the level going high raises the INTA-assert request. It appears two clock edges after a mailbox set pulse is sampled, or one edge after an app_irq change.
- R5: With legacy allowed and INTA asserted, the level going low raises the INTA-deassert request.
- R6: Setting legacy-disable while INTA is asserted raises the INTA-deassert request, even if the level is still high.
- R7: Allowing legacy while the level is already high raises the INTA-assert request.
- R8: With MSI enabled, the level being high and not yet served raises the MSI request. After its handshake, no further MSI is raised until the level has been low for at least one cycle.
- R9: While both types are enabled, new interrupts are sent only as MSI, never as INTA-assert.
- R10: When MSI becomes enabled while INTA is asserted and the level is high, the INTA deassert is sent first and an MSI follows, so the pending interrupt is not dropped.
- R11: At most one request output is high at a time. A request that is not acknowledged keeps its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_set | input | 8 | Per-mailbox set pulses from sources |
| mbox_clr_we | input | 1 | Write-one-to-clear strobe for status |
| mbox_clr_mask | input | 8 | Bits to clear when the strobe is high |
| irq_en_we | input | 1 | Enable word write strobe |
| irq_en_wdata | input | 9 | New enable word; bit 8 enables app_irq |
| app_irq | input | 1 | Application interrupt level |
| cfg_intx_disable | input | 1 | Legacy interrupt disable (Command bit 10) |
| cfg_msi_enable | input | 1 | MSI enable (MSI control bit 0) |
| msg_ack | input | 1 | Ready: the visible request has been taken |
| msi_req | output | 1 | Valid: send an MSI |
| inta_assert_req | output | 1 | Valid: send an INTA assert message |
| inta_deassert_req | output | 1 | Valid: send an INTA deassert message |

## Verification
The assertions assume that `msg_ack` is high only in cycles where a request is visible. They also assume that set pulses and clear strobes are single-cycle signals, driven on the opposite clock edge. The stimulus drives `msg_ack` from a monitor that raises it only after it has seen a request. Every input changes at the falling edge. Mode switches follow the software order: enable the new type first, then disable the old one.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    MSG_NONE     = 2'd0,
    MSG_MSI      = 2'd1,
    MSG_INTA_ON  = 2'd2,
    MSG_INTA_OFF = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_MBOX = 8,
  localparam int EN_W = N_MBOX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] mbox_set,
  input  logic              mbox_clr_we,
  input  logic [N_MBOX-1:0] mbox_clr_mask,
  input  logic              irq_en_we,
  input  logic [EN_W-1:0]   irq_en_wdata,
  input  logic              app_irq,
  output logic              irq_level
);
  logic [N_MBOX-1:0] status_q;
  logic [EN_W-1:0]   enable_q;

  for (genvar i = 0; i < N_MBOX; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rst_n)                                status_q[i] <= 1'b0;
      else if (mbox_set[i])                      status_q[i] <= 1'b1;
      else if (mbox_clr_we && mbox_clr_mask[i])  status_q[i] <= 1'b0;
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mbox_set[i] |=> status_q[i]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_clr_we && mbox_clr_mask[i] && !mbox_set[i]) |=> !status_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         enable_q <= '0;
    else if (irq_en_we) enable_q <= irq_en_wdata;
  end

  always_comb begin
    irq_level = |(status_q & enable_q[N_MBOX-1:0]);
    irq_level = irq_level | (app_irq & enable_q[N_MBOX]);
  end

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_level);
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_level,
  input  logic cfg_intx_disable,
  input  logic cfg_msi_enable,
  input  logic msg_ack,
  output logic msi_req,
  output logic inta_assert_req,
  output logic inta_deassert_req
);
  msg_kind_e cur_q;
  logic      inta_on_q;
  logic      msi_done_q;
  logic      legacy_ok, want_inta, need_off, need_on, need_msi;

  always_comb begin
    legacy_ok = !cfg_intx_disable && !cfg_msi_enable;
    want_inta = irq_level && legacy_ok;
    need_off  = inta_on_q && !want_inta;
    need_on   = !inta_on_q && want_inta;
    need_msi  = cfg_msi_enable && irq_level && !msi_done_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= MSG_NONE;
      inta_on_q  <= 1'b0;
      msi_done_q <= 1'b0;
    end else begin
      if (cur_q == MSG_NONE) begin
        if (need_off)      cur_q <= MSG_INTA_OFF;
        else if (need_msi) cur_q <= MSG_MSI;
        else if (need_on)  cur_q <= MSG_INTA_ON;
      end else if (msg_ack) begin
        cur_q <= MSG_NONE;
        case (cur_q)
          MSG_INTA_ON:  inta_on_q <= 1'b1;
          MSG_INTA_OFF: inta_on_q <= 1'b0;
          default: ;
        endcase
      end
      if (cur_q == MSG_MSI && msg_ack) msi_done_q <= 1'b1;
      else if (!irq_level)             msi_done_q <= 1'b0;
    end
  end

  assign msi_req           = (cur_q == MSG_MSI);
  assign inta_assert_req   = (cur_q == MSG_INTA_ON);
  assign inta_deassert_req = (cur_q == MSG_INTA_OFF);

  assert_one_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msi_req, inta_assert_req, inta_deassert_req}));
  assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((msi_req || inta_assert_req || inta_deassert_req) && !msg_ack)
      |=> $stable({msi_req, inta_assert_req, inta_deassert_req}));
  assert_assert_needs_legacy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_assert_req) |-> $past(irq_level && !cfg_intx_disable && !cfg_msi_enable));
  assert_msi_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req) |-> $past(cfg_msi_enable && irq_level));
  assert_deassert_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_deassert_req) |-> $past(!irq_level || cfg_intx_disable || cfg_msi_enable));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_MBOX = 8,
  localparam int EN_W = N_MBOX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] mbox_set,
  input  logic              mbox_clr_we,
  input  logic [N_MBOX-1:0] mbox_clr_mask,
  input  logic              irq_en_we,
  input  logic [EN_W-1:0]   irq_en_wdata,
  input  logic              app_irq,
  input  logic              cfg_intx_disable,
  input  logic              cfg_msi_enable,
  input  logic              msg_ack,
  output logic              msi_req,
  output logic              inta_assert_req,
  output logic              inta_deassert_req
);
  logic irq_level;

  irq_src_bank #(.N_MBOX(N_MBOX)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .mbox_set      (mbox_set),
    .mbox_clr_we   (mbox_clr_we),
    .mbox_clr_mask (mbox_clr_mask),
    .irq_en_we     (irq_en_we),
    .irq_en_wdata  (irq_en_wdata),
    .app_irq       (app_irq),
    .irq_level     (irq_level)
  );

  irq_msg_ctrl u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .irq_level         (irq_level),
    .cfg_intx_disable  (cfg_intx_disable),
    .cfg_msi_enable    (cfg_msi_enable),
    .msg_ack           (msg_ack),
    .msi_req           (msi_req),
    .inta_assert_req   (inta_assert_req),
    .inta_deassert_req (inta_deassert_req)
  );
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  localparam int N = 8;
  // expected message codes used by this bench only
  localparam int K_MSI = 1, K_ON = 2, K_OFF = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [N-1:0] mbox_set = '0;
  logic         mbox_clr_we = 1'b0;
  logic [N-1:0] mbox_clr_mask = '0;
  logic         irq_en_we = 1'b0;
  logic [N:0]   irq_en_wdata = '0;
  logic         app_irq = 1'b0;
  logic         cfg_intx_disable = 1'b0;
  logic         cfg_msi_enable = 1'b0;
  logic         msg_ack = 1'b0;
  logic         msi_req, inta_assert_req, inta_deassert_req;

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    ack_hold = 1'b0;

  irq_aggregator #(.N_MBOX(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .mbox_set(mbox_set), .mbox_clr_we(mbox_clr_we),
    .mbox_clr_mask(mbox_clr_mask), .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata),
    .app_irq(app_irq), .cfg_intx_disable(cfg_intx_disable), .cfg_msi_enable(cfg_msi_enable),
    .msg_ack(msg_ack), .msi_req(msi_req), .inta_assert_req(inta_assert_req),
    .inta_deassert_req(inta_deassert_req)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kind_now();
    int n;
    n = int'(msi_req) + int'(inta_assert_req) + int'(inta_deassert_req);
    if (n > 1) return 9;
    if (msi_req) return K_MSI;
    if (inta_assert_req) return K_ON;
    if (inta_deassert_req) return K_OFF;
    return 0;
  endfunction

  task automatic expect_msg(int k, string t);
    exp_q.push_back(k);
    tag_q.push_back(t);
  endtask

  // monitor: takes each request, compares against the scoreboard, acknowledges
  initial begin
    forever begin
      @(negedge clk);
      msg_ack = 1'b0;
      if (rst_n && !ack_hold && kind_now() != 0) begin
        int k;
        k = kind_now();
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected message", k, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(k == e, t, k, e);
        end
        msg_ack = 1'b1;
      end
    end
  end

  task automatic drain(string t);
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic pulse_set(int idx);
    @(negedge clk);
    mbox_set[idx] = 1'b1;
    @(negedge clk);
    mbox_set = '0;
  endtask

  task automatic clr(logic [N-1:0] m);
    @(negedge clk);
    mbox_clr_we = 1'b1;
    mbox_clr_mask = m;
    @(negedge clk);
    mbox_clr_we = 1'b0;
    mbox_clr_mask = '0;
  endtask

  task automatic wr_en(logic [N:0] v);
    @(negedge clk);
    irq_en_we = 1'b1;
    irq_en_wdata = v;
    @(negedge clk);
    irq_en_we = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(kind_now() == 0, "R1 reset quiet", kind_now(), 0);

    // R2: a status bit with its enable clear is ignored
    pulse_set(3);
    repeat (5) @(negedge clk);
    check(kind_now() == 0, "R2 masked source", kind_now(), 0);

    expect_msg(K_ON, "R4 enable exposes status");
    wr_en(9'h008);
    drain("R4 drain");
    expect_msg(K_OFF, "R5 clear drops level");
    clr(8'h08);
    drain("R5 drain");

    // R2: application input through enable bit 8
    wr_en(9'h100);
    expect_msg(K_ON, "R2 app assert");
    @(negedge clk); app_irq = 1'b1;
    drain("R2 app drain");
    expect_msg(K_OFF, "R5 app deassert");
    @(negedge clk); app_irq = 1'b0;
    drain("R5 app drain");

    // R4 latency and R11 hold while not acknowledged
    wr_en(9'h001);
    ack_hold = 1'b1;
    pulse_set(0);
    check(kind_now() == 0, "R4 not before second edge", kind_now(), 0);
    @(negedge clk);
    check(kind_now() == K_ON, "R4 latency", kind_now(), K_ON);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(kind_now() == K_ON, "R11 held without ack", kind_now(), K_ON);
    end
    expect_msg(K_ON, "R4 assert taken");
    ack_hold = 1'b0;
    drain("R4 hold drain");

    expect_msg(K_OFF, "R6 disable while asserted");
    @(negedge clk); cfg_intx_disable = 1'b1;
    drain("R6 drain");
    expect_msg(K_ON, "R7 re-allow with level high");
    @(negedge clk); cfg_intx_disable = 1'b0;
    drain("R7 drain");

    // R10: switch to MSI with INTA asserted and level high
    expect_msg(K_OFF, "R10 deassert first");
    expect_msg(K_MSI, "R10 msi follows");
    @(negedge clk); cfg_msi_enable = 1'b1;
    drain("R10 drain");
    @(negedge clk); cfg_intx_disable = 1'b1;
    repeat (10) @(negedge clk);
    check(kind_now() == 0, "R8 no repeat while high", kind_now(), 0);
    clr(8'h01);
    drain("R8 low quiet");
    expect_msg(K_MSI, "R8 new high period");
    pulse_set(0);
    drain("R8 drain");
    clr(8'h01);

    // R9: both enabled, new interrupt goes as MSI only
    @(negedge clk); cfg_intx_disable = 1'b0;
    repeat (3) @(negedge clk);
    expect_msg(K_MSI, "R9 msi only");
    pulse_set(0);
    drain("R9 drain");
    clr(8'h01);
    drain("R9 clear quiet");

    // R3: set wins over clear in the same cycle
    expect_msg(K_MSI, "R3 set wins");
    @(negedge clk);
    mbox_set[0] = 1'b1; mbox_clr_we = 1'b1; mbox_clr_mask = 8'h01;
    @(negedge clk);
    mbox_set = '0; mbox_clr_we = 1'b0; mbox_clr_mask = '0;
    drain("R3 drain");
    clr(8'h01);
    // status must now be clear: leaving MSI for legacy must not assert INTA
    @(negedge clk); cfg_msi_enable = 1'b0;
    drain("R3 cleared bit stays quiet");
    check(kind_now() == 0, "R3 final quiet", kind_now(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule